// File: doc/BRIEF.md
# I2C Slave Write Receiver

This block is the receive side of a 7-bit-addressed I2C target. It watches the open-drain SCL and SDA lines, recognises START and STOP, and takes part in a transfer only when the address byte carries its own address with the direction bit set for a write. Every data byte it accepts goes into a receive FIFO. A host drains the FIFO through a show-ahead read port: a strobe pops the oldest byte.

The host sees a byte count, a data-present bit and four sticky event flags. The flags report that the FIFO is nearly full, that an addressed write has ended, that a byte was refused, and that a clock stretch has lasted too long. When the FIFO is full the block either refuses the byte with a NACK, or, with hold enabled, keeps SCL low until the host reads. Bus sampling is paced by an external clock-enable pulse. The lines go through a reset-to-high synchroniser first.

Top module: `i2c_rx_slave`

## Requirements
- R1: After reset both line drivers are released, `xfer_size` is 0, `rx_valid` is 0 and all bits of `irq_flags` are 0.
- R2: The ninth clock of an address byte is acknowledged (SDA driven low) only when the upper seven bits equal `own_addr` and the last bit is 0. On any other address byte the block does not acknowledge and ignores the bus until the next START, so the data bytes that follow are neither acknowledged nor stored.
- R3: Each acknowledged data byte is appended to the FIFO. `rd_data` shows the oldest stored byte, a pulse on `rd_stb` removes it, bytes leave in arrival order, and `rx_valid` is 1 exactly while the FIFO holds at least one byte.
- R4: `xfer_size` equals the number of bytes waiting in the FIFO. It rises by one per stored byte, falls by one per host read, and a read of an empty FIFO changes nothing.
- R5: `irq_flags` bit 0 is set when a stored byte leaves exactly two free entries (14 of 16 with the default depth).
- R6: `irq_flags` bit 1 is set by a STOP that ends a transfer in which the block acknowledged its address. A STOP after an ignored address does not set it.
- R7: With `hold_en` low, a data byte that arrives while the FIFO is full is not acknowledged, `irq_flags` bit 2 is set, and the FIFO contents and `xfer_size` stay unchanged.
- R8: With `hold_en` high, a data byte that arrives while the FIFO is full makes the block drive SCL low. SCL is released only after a host read frees an entry. The byte is then stored and acknowledged.
- R9: When SCL has been held for more than `timeout_lim` clock-enable pulses, `irq_flags` bit 3 is set.
- R10: Each `irq_flags` bit stays set until the host writes a 1 to the same bit of `irq_clr`. Writing 0 to a bit leaves that bit unchanged.
- R11: The lines are evaluated only on cycles with `tick` high. While `tick` stays low, bus activity is neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Clock-enable pulse that paces bus sampling |
| scl_i | input | 1 | Observed SCL line level |
| sda_i | input | 1 | Observed SDA line level |
| scl_drive_low | output | 1 | Pulls SCL low (clock stretch) when 1 |
| sda_drive_low | output | 1 | Pulls SDA low (acknowledge) when 1 |
| own_addr | input | 7 | Address this target answers to |
| hold_en | input | 1 | Stretch SCL instead of refusing a byte when full |
| timeout_lim | input | TMO_W | Stretch limit in `tick` pulses |
| rd_stb | input | 1 | Host read: pop the oldest byte |
| rd_data | output | 8 | Oldest byte in the FIFO |
| xfer_size | output | $clog2(DEPTH+1) | Bytes waiting in the FIFO |
| rx_valid | output | 1 | FIFO holds at least one byte |
| irq_flags | output | 4 | Sticky flags: 0 nearly full, 1 complete, 2 overflow, 3 timeout |
| irq_clr | input | 4 | Write-one-to-clear mask for `irq_flags` |

## Verification
A change on the lines reaches the protocol engine after the synchroniser stages plus up to one `tick` period. The acknowledge, stretch and push decisions are registered one clock later, and the FIFO count and flags follow on the next clock. That puts every bus-side result within about six clocks of the line change. The bench holds each bus phase for ten clocks and compares host-visible state against its model only between bus phases, once all of that latency has passed. A host read or flag clear is compared at the first falling edge after the rising edge that consumes it. The model pops or clears on that same edge.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_DATA,
      ST_DACK,
      ST_HOLD
   } rx_state_t;

   localparam int FLG_NEAR = 0;
   localparam int FLG_DONE = 1;
   localparam int FLG_OVF  = 2;
   localparam int FLG_TMO  = 3;
   localparam int NFLAGS   = 4;
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
   parameter int         W       = 2,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_rx_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[0] <= RST_VAL;
      else        stg[0] <= d;

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n) stg[g] <= RST_VAL;
         else        stg[g] <= stg[g-1];
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_rx_fifo.sv
module i2c_rx_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("i2c_rx_fifo: DEPTH must be a power of two, at least 4");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign full    = (count == FULL_CNT);
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = mem[rptr];

   always_ff @(posedge clk)
      if (do_push) mem[wptr] <= push_data;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
   import i2c_rx_pkg::*;
#(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             scl_s,
   input  logic             sda_s,
   input  logic [6:0]       own_addr,
   input  logic             hold_en,
   input  logic [TMO_W-1:0] timeout_lim,
   input  logic             fifo_full,
   output logic             push,
   output logic [7:0]       push_data,
   output logic             sda_drv,
   output logic             scl_drv,
   output logic             ev_done,
   output logic             ev_ovf,
   output logic             ev_tmo
);
   rx_state_t        state;
   logic             scl_p, sda_p;
   logic [3:0]       bits;
   logic [7:0]       shreg;
   logic             active;
   logic [TMO_W-1:0] tcnt;
   logic             tdone;
   logic             rise, fall, start_c, stop_c, byte_end;

   assign rise     = tick &&  scl_s && !scl_p;
   assign fall     = tick && !scl_s &&  scl_p;
   assign start_c  = tick && scl_s && scl_p &&  sda_p && !sda_s;
   assign stop_c   = tick && scl_s && scl_p && !sda_p &&  sda_s;
   assign byte_end = fall && (bits == 4'd8);
   assign push_data = shreg;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else if (tick) begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state   <= ST_IDLE;
         bits    <= '0;
         shreg   <= '0;
         active  <= 1'b0;
         tcnt    <= '0;
         tdone   <= 1'b0;
         push    <= 1'b0;
         sda_drv <= 1'b0;
         scl_drv <= 1'b0;
         ev_done <= 1'b0;
         ev_ovf  <= 1'b0;
         ev_tmo  <= 1'b0;
      end else begin
         push    <= 1'b0;
         ev_done <= 1'b0;
         ev_ovf  <= 1'b0;
         ev_tmo  <= 1'b0;
         if (start_c) begin
            state   <= ST_ADDR;
            bits    <= '0;
            sda_drv <= 1'b0;
            scl_drv <= 1'b0;
         end else if (stop_c) begin
            state   <= ST_IDLE;
            sda_drv <= 1'b0;
            scl_drv <= 1'b0;
            active  <= 1'b0;
            ev_done <= active;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (rise) begin
                     shreg <= {shreg[6:0], sda_s};
                     bits  <= bits + 1'b1;
                  end else if (byte_end) begin
                     if (shreg[7:1] == own_addr && !shreg[0]) begin
                        sda_drv <= 1'b1;
                        active  <= 1'b1;
                        state   <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK, ST_DACK: begin
                  if (fall) begin
                     sda_drv <= 1'b0;
                     bits    <= '0;
                     state   <= ST_DATA;
                  end
               end
               ST_DATA: begin
                  if (rise) begin
                     shreg <= {shreg[6:0], sda_s};
                     bits  <= bits + 1'b1;
                  end else if (byte_end) begin
                     if (!fifo_full) begin
                        push    <= 1'b1;
                        sda_drv <= 1'b1;
                        state   <= ST_DACK;
                     end else if (hold_en) begin
                        scl_drv <= 1'b1;
                        tcnt    <= '0;
                        tdone   <= 1'b0;
                        state   <= ST_HOLD;
                     end else begin
                        ev_ovf <= 1'b1;
                        state  <= ST_DACK;
                     end
                  end
               end
               ST_HOLD: begin
                  if (!fifo_full) begin
                     push    <= 1'b1;
                     sda_drv <= 1'b1;
                     scl_drv <= 1'b0;
                     state   <= ST_DACK;
                  end else if (tick) begin
                     if (tcnt == timeout_lim && !tdone) begin
                        ev_tmo <= 1'b1;
                        tdone  <= 1'b1;
                     end
                     if (tcnt != '1) tcnt <= tcnt + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
endmodule

// File: rtl/i2c_rx_slave.sv
module i2c_rx_slave
   import i2c_rx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int TMO_W       = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         tick,
   input  logic                         scl_i,
   input  logic                         sda_i,
   output logic                         scl_drive_low,
   output logic                         sda_drive_low,
   input  logic [6:0]                   own_addr,
   input  logic                         hold_en,
   input  logic [TMO_W-1:0]             timeout_lim,
   input  logic                         rd_stb,
   output logic [7:0]                   rd_data,
   output logic [$clog2(DEPTH+1)-1:0]   xfer_size,
   output logic                         rx_valid,
   output logic [NFLAGS-1:0]            irq_flags,
   input  logic [NFLAGS-1:0]            irq_clr
);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] NEAR_AT = CW'(DEPTH - 3);

   logic [1:0]        lines_s;
   logic              push, full, empty;
   logic [7:0]        push_data;
   logic              ev_done, ev_ovf, ev_tmo;
   logic [NFLAGS-1:0] set_vec;

   i2c_rx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scl_i, sda_i}),
      .q     (lines_s)
   );

   i2c_rx_engine #(.TMO_W(TMO_W)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .scl_s       (lines_s[1]),
      .sda_s       (lines_s[0]),
      .own_addr    (own_addr),
      .hold_en     (hold_en),
      .timeout_lim (timeout_lim),
      .fifo_full   (full),
      .push        (push),
      .push_data   (push_data),
      .sda_drv     (sda_drive_low),
      .scl_drv     (scl_drive_low),
      .ev_done     (ev_done),
      .ev_ovf      (ev_ovf),
      .ev_tmo      (ev_tmo)
   );

   i2c_rx_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (rd_stb),
      .head      (rd_data),
      .count     (xfer_size),
      .full      (full),
      .empty     (empty)
   );

   assign rx_valid = !empty;

   always_comb begin
      set_vec           = '0;
      set_vec[FLG_NEAR] = push && !full && (xfer_size == NEAR_AT);
      set_vec[FLG_DONE] = ev_done;
      set_vec[FLG_OVF]  = ev_ovf;
      set_vec[FLG_TMO]  = ev_tmo;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) irq_flags <= '0;
      else        irq_flags <= (irq_flags & ~irq_clr) | set_vec;
endmodule

// File: rtl/i2c_rx_chk.sv
module i2c_rx_chk
   import i2c_rx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_en,
   input logic              scl_drive_low,
   input logic              sda_drive_low,
   input logic [CW-1:0]     xfer_size,
   input logic [NFLAGS-1:0] irq_flags,
   input logic [NFLAGS-1:0] irq_clr
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   p_size_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_size <= FULL_CNT);

   p_size_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_size == $past(xfer_size)) ||
      (xfer_size == $past(xfer_size) + 1'b1) ||
      ($past(xfer_size) == xfer_size + 1'b1));

   p_hold_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_drive_low) |-> ($past(hold_en) && $past(xfer_size) == FULL_CNT));

   p_no_dual_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_drive_low && sda_drive_low));

   p_tmo_while_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[FLG_TMO]) |-> $past(scl_drive_low));

   p_flags_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(irq_flags) & ~$past(irq_clr)) & ~irq_flags) == '0));
endmodule

bind i2c_rx_slave i2c_rx_chk #(.DEPTH(DEPTH)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .hold_en       (hold_en),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low),
   .xfer_size     (xfer_size),
   .irq_flags     (irq_flags),
   .irq_clr       (irq_clr)
);

// File: tb/test_i2c_rx_slave.sv
module test_i2c_rx_slave;
   localparam int DEPTH = 16;
   localparam logic [6:0] OWN = 7'h2A;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       tick_en = 1'b1;
   logic       m_scl = 1'b1, m_sda = 1'b1;
   logic       hold_en = 1'b0;
   logic [7:0] timeout_lim = 8'd20;
   logic       rd_stb = 1'b0;
   logic [3:0] irq_clr = 4'h0;
   logic       scl_drive_low, sda_drive_low, rx_valid;
   logic [7:0] rd_data;
   logic [4:0] xfer_size;
   logic [3:0] irq_flags;

   wire scl_line = m_scl & ~scl_drive_low;
   wire sda_line = m_sda & ~sda_drive_low;

   int   n_tests = 0, n_fail = 0;
   bit   chk_on = 1'b0;
   logic [7:0] q[$];
   logic [3:0] exp_flags = 4'h0;

   always #5 clk = ~clk;
   always @(posedge clk) tick <= tick_en && !tick;

   i2c_rx_slave #(.DEPTH(DEPTH)) i_i2c_rx_slave (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .scl_i(scl_line), .sda_i(sda_line),
      .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
      .own_addr(OWN), .hold_en(hold_en), .timeout_lim(timeout_lim),
      .rd_stb(rd_stb), .rd_data(rd_data), .xfer_size(xfer_size),
      .rx_valid(rx_valid), .irq_flags(irq_flags), .irq_clr(irq_clr)
   );

   function automatic void chk(bit ok, string req, int act, int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endfunction

   // per-clock comparison against the reference model between bus phases
   always @(negedge clk) if (chk_on && rst_n) begin
      chk(xfer_size == q.size(), "R4 xfer_size", xfer_size, q.size());
      chk(rx_valid == (q.size() != 0), "R3 rx_valid", rx_valid, q.size() != 0);
      if (q.size() != 0) chk(rd_data == q[0], "R3 rd_data", rd_data, q[0]);
      chk(irq_flags == exp_flags, "R5/R6/R7/R9/R10 irq_flags", irq_flags, exp_flags);
   end

   task automatic half();
      repeat (10) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; half();
      m_sda = 1'b0; half();
      m_scl = 1'b0; half();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; half();
      m_scl = 1'b1; wait (scl_line); half();
      m_sda = 1'b1; half();
   endtask

   task automatic send_bits(input logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         m_sda = d[i]; half();
         m_scl = 1'b1; wait (scl_line); @(negedge clk); half();
         m_scl = 1'b0; half();
      end
   endtask

   task automatic ack_clk(output bit acked);
      m_sda = 1'b1; half();
      m_scl = 1'b1; wait (scl_line); @(negedge clk); half();
      acked = !sda_line;
      m_scl = 1'b0; half();
   endtask

   // data byte with model update; expected ack computed from FIFO space
   task automatic data_byte(input logic [7:0] d);
      bit a;
      bit want;
      want = (q.size() < DEPTH);
      send_bits(d);
      ack_clk(a);
      chk(a == want, want ? "R3 ack of stored byte" : "R7 nack when full", a, want);
      if (want) begin
         q.push_back(d);
         if (q.size() == DEPTH - 2) exp_flags[0] = 1'b1;
      end else if (!hold_en) begin
         exp_flags[2] = 1'b1;
      end
   endtask

   task automatic host_read();
      rd_stb = 1'b1;
      @(posedge clk);
      if (q.size() != 0) void'(q.pop_front());
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic host_clr(input logic [3:0] m);
      irq_clr = m;
      @(posedge clk);
      exp_flags = exp_flags & ~m;
      @(negedge clk);
      irq_clr = 4'h0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      bit a;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(scl_drive_low == 1'b0, "R1 scl released", scl_drive_low, 0);
      chk(sda_drive_low == 1'b0, "R1 sda released", sda_drive_low, 0);
      chk(xfer_size == 0, "R1 xfer_size", xfer_size, 0);
      chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
      chk(irq_flags == 4'h0, "R1 flags", irq_flags, 0);
      chk_on = 1'b1;

      // R11: no tick, nothing recognised
      tick_en = 1'b0;
      chk_on = 1'b0;
      bus_start();
      send_bits({OWN, 1'b0}); ack_clk(a);
      chk(a == 1'b0, "R11 no ack without tick", a, 0);
      send_bits(8'h55); ack_clk(a);
      chk(a == 1'b0, "R11 no data ack without tick", a, 0);
      bus_stop();
      chk(xfer_size == 0, "R11 nothing stored", xfer_size, 0);
      chk(irq_flags == 4'h0, "R11 no flags", irq_flags, 0);
      tick_en = 1'b1;
      half();
      chk_on = 1'b1;

      // R2/R3/R6 addressed write of three bytes
      chk_on = 1'b0;
      bus_start();
      send_bits({OWN, 1'b0}); ack_clk(a);
      chk(a == 1'b1, "R2 own address acked", a, 1);
      data_byte(8'hA5);
      data_byte(8'h3C);
      data_byte(8'hF0);
      bus_stop();
      exp_flags[1] = 1'b1;
      chk(irq_flags[1] == 1'b1, "R6 complete after stop", irq_flags[1], 1);
      chk_on = 1'b1;
      chk(rd_data == 8'hA5, "R3 oldest byte first", rd_data, 8'hA5);
      host_read(); host_read(); host_read();
      chk(rx_valid == 1'b0, "R3 rx_valid cleared when empty", rx_valid, 0);
      host_read();
      chk(xfer_size == 0, "R4 read of empty FIFO ignored", xfer_size, 0);

      // R10 clear with zero mask, then one bit
      host_clr(4'h0);
      chk(irq_flags[1] == 1'b1, "R10 zero write keeps flag", irq_flags[1], 1);
      host_clr(4'h2);
      chk(irq_flags == 4'h0, "R10 write-one clears flag", irq_flags, 0);

      // R2/R6 wrong address and read direction
      chk_on = 1'b0;
      bus_start();
      send_bits({OWN ^ 7'h01, 1'b0}); ack_clk(a);
      chk(a == 1'b0, "R2 foreign address not acked", a, 0);
      send_bits(8'h81); ack_clk(a);
      chk(a == 1'b0, "R2 data after foreign address ignored", a, 0);
      bus_stop();
      bus_start();
      send_bits({OWN, 1'b1}); ack_clk(a);
      chk(a == 1'b0, "R2 read direction not acked", a, 0);
      bus_stop();
      chk(irq_flags[1] == 1'b0, "R6 no complete when unaddressed", irq_flags[1], 0);
      chk_on = 1'b1;
      half();

      // R5/R7 fill the FIFO then overflow
      chk_on = 1'b0;
      bus_start();
      send_bits({OWN, 1'b0}); ack_clk(a);
      chk(a == 1'b1, "R2 own address acked", a, 1);
      for (int i = 0; i < DEPTH; i++) begin
         data_byte(8'h10 + 8'(i));
         if (i == DEPTH - 3)
            chk(irq_flags[0] == 1'b1, "R5 nearly-full at two free", irq_flags[0], 1);
         if (i == DEPTH - 4)
            chk(irq_flags[0] == 1'b0, "R5 not yet nearly-full", irq_flags[0], 0);
      end
      data_byte(8'h99);
      chk(irq_flags[2] == 1'b1, "R7 overflow flag", irq_flags[2], 1);
      chk(xfer_size == 5'(DEPTH), "R7 FIFO unchanged", xfer_size, DEPTH);
      chk(rd_data == 8'h10, "R7 head unchanged", rd_data, 8'h10);
      bus_stop();
      exp_flags[1] = 1'b1;
      chk_on = 1'b1;
      half();
      host_clr(4'hF);

      // R8/R9 hold mode with timeout
      hold_en = 1'b1;
      chk_on = 1'b0;
      bus_start();
      send_bits({OWN, 1'b0}); ack_clk(a);
      chk(a == 1'b1, "R2 own address acked when full", a, 1);
      send_bits(8'h77);
      chk(scl_drive_low == 1'b1, "R8 SCL held when full", scl_drive_low, 1);
      chk(irq_flags[3] == 1'b0, "R9 no timeout yet", irq_flags[3], 0);
      repeat (60) @(negedge clk);
      chk(irq_flags[3] == 1'b1, "R9 timeout flag", irq_flags[3], 1);
      chk(scl_drive_low == 1'b1, "R8 SCL still held", scl_drive_low, 1);
      exp_flags[3] = 1'b1;
      host_read();
      ack_clk(a);
      chk(a == 1'b1, "R8 byte acked after read", a, 1);
      chk(scl_drive_low == 1'b0, "R8 SCL released", scl_drive_low, 0);
      q.push_back(8'h77);
      bus_stop();
      exp_flags[1] = 1'b1;
      chk_on = 1'b1;
      hold_en = 1'b0;
      half();

      // R3/R4 drain in order
      for (int i = 0; i < DEPTH; i++) host_read();
      chk(rx_valid == 1'b0, "R3 empty after drain", rx_valid, 0);
      chk(xfer_size == 0, "R4 size zero after drain", xfer_size, 0);
      half();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule